// File: doc/BRIEF.md
# Two-Master Fixed-Priority Bus Arbiter

This block decides which of two masters drives a shared on-chip bus: the CPU or a data-transfer engine that moves data on behalf of software. Each master has a request input and an acknowledge output. The transfer engine has the higher priority. The CPU is the default owner and holds the bus whenever the engine is not asking for it.

A pending engine request does not take the bus from the CPU at once. The CPU gives the bus up only at a safe point, and there are three of them:
- the end of a CPU bus cycle that is not inside an indivisible multi-cycle access;
- any clock on which the CPU has no access in progress;
- any clock on which the CPU is asleep.

The CPU marks the end of each of its bus cycles with a strobe. It holds a lock signal high during every cycle of an indivisible access except the last. For example, a longword done as two word cycles carries lock on the first word only, so the end of the first word is not a safe point.

The engine keeps the bus for as long as it keeps its request high. It drops the request at the end of one of its own bus cycles, and ownership returns to the CPU. Both acknowledges come from registers. Any change of owner appears on the acknowledges one clock after the edge at which the qualifying condition was sampled.

Top module: `bus_owner_arb`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) gives cpu_ack=1 and xfr_ack=0 from that edge on, whoever owned the bus before.
- R2: Exactly one of cpu_ack and xfr_ack is high in every cycle.
- R3: While xfr_req is low and the CPU owns the bus, cpu_ack stays high whatever the CPU inputs do.
- R4: If the CPU owns the bus with cpu_req high, and at a rising edge xfr_req=1, cpu_cyc_end=1 and cpu_lock=0, then xfr_ack is high and cpu_ack low from that edge on (a one-clock handover).
- R5: If the CPU owns the bus with cpu_req high and cpu_sleep low, an edge with cpu_cyc_end=0 leaves cpu_ack high even when xfr_req is high.
- R6: If the CPU owns the bus with cpu_req high and cpu_sleep low, an edge with cpu_lock=1 leaves cpu_ack high even when cpu_cyc_end and xfr_req are both high. The bus is therefore never handed over between the cycles of a locked access.
- R7: If the CPU owns the bus and an edge samples cpu_sleep=1 with xfr_req=1, the bus goes to the engine at that edge regardless of cpu_cyc_end and cpu_lock.
- R8: If the CPU owns the bus and an edge samples cpu_req=0 with xfr_req=1, the bus goes to the engine at that edge without any cycle-end strobe.
- R9: While the engine owns the bus, it keeps xfr_ack high on every edge at which xfr_req is high, whatever the CPU inputs are.
- R10: While the engine owns the bus, an edge that samples xfr_req=0 returns the bus to the CPU: cpu_ack=1 and xfr_ack=0 from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU has an access in progress or pending |
| cpu_cyc_end | input | 1 | Last clock of the current CPU bus cycle |
| cpu_lock | input | 1 | Current CPU cycle is part of an indivisible access and is not its last cycle |
| cpu_sleep | input | 1 | CPU is in sleep mode |
| xfr_req | input | 1 | Transfer engine requests the bus; dropped only at its own cycle end |
| cpu_ack | output | 1 | CPU owns the bus (registered) |
| xfr_ack | output | 1 | Transfer engine owns the bus (registered) |

## Verification
The properties assume two things about the masters. The engine lowers xfr_req only at the end of one of its own bus cycles. The CPU raises cpu_lock on every cycle of an indivisible access except the last. The arbiter cannot see whether either rule is kept, so the checker does not test them. It checks only the ownership outcome implied by each input combination sampled at an edge. The bench drives all inputs on the falling edge and reads the acknowledges on the next falling edge. Its locked-access sequence keeps to the lock rule: lock is high on the first word's strobe and low on the second word's strobe.

// File: rtl/bus_arb_pkg.sv
// Package: shared owner encoding and acknowledge decode for the bus arbiter.
// Assumes exactly two masters; the index of each master is its acknowledge bit.
package bus_arb_pkg;

    localparam int NUM_MASTERS = 2;
    localparam int OWNER_W     = $clog2(NUM_MASTERS);

    // Master index doubles as the owner encoding.
    typedef enum logic [OWNER_W-1:0] {
        OWN_CPU = 1'b0,
        OWN_XFR = 1'b1
    } owner_e;

    // One-hot acknowledge vector for a given owner.
    function automatic logic [NUM_MASTERS-1:0] owner_to_ack(owner_e who);
        logic [NUM_MASTERS-1:0] v;
        v = '0;
        v[who] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/arb_yield_gate.sv
// Module: decides whether the CPU may give up the bus on this clock.
// Assumes cpu_lock is high on every cycle of an indivisible access except
// its last, so a strobe with lock high lies inside the access.
module arb_yield_gate (
    input  logic cpu_req,
    input  logic cpu_cyc_end,
    input  logic cpu_lock,
    input  logic cpu_sleep,
    output logic cpu_can_yield
);

    logic at_boundary;

    // Purpose: a free boundary is a cycle end that is outside a locked access.
    always_comb begin
        at_boundary = cpu_cyc_end & ~cpu_lock;
    end

    // Purpose: the CPU may yield when asleep, when idle, or at a free boundary.
    always_comb begin
        cpu_can_yield = cpu_sleep | ~cpu_req | at_boundary;
    end

endmodule

// File: rtl/arb_owner_fsm.sv
// Module: ownership state machine with fixed priority (engine over CPU).
// Provides both the current owner and the next-state value, which the
// acknowledge register captures. Assumes the engine drops its request only
// at one of its own cycle boundaries.
module arb_owner_fsm
    import bus_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   xfr_req,
    input  logic   cpu_can_yield,
    output owner_e owner_q,
    output owner_e owner_d
);

    // Purpose: pick the next owner from the current owner and the requests.
    always_comb begin
        owner_d = owner_q;
        unique case (owner_q)
            OWN_CPU: if (xfr_req && cpu_can_yield) owner_d = OWN_XFR;
            OWN_XFR: if (!xfr_req)                 owner_d = OWN_CPU;
            default:                               owner_d = OWN_CPU;
        endcase
    end

    // Purpose: hold the owner; reset makes the CPU the owner.
    always_ff @(posedge clk) begin
        if (!rst_n) owner_q <= OWN_CPU;
        else        owner_q <= owner_d;
    end

endmodule

// File: rtl/arb_ack_reg.sv
// Module: registered one-hot acknowledge outputs, one flop per master.
// Assumes owner_d is the owner for the coming clock; the output appears one
// clock after the edge that samples it.
module arb_ack_reg
    import bus_arb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  owner_e                 owner_d,
    output logic [NUM_MASTERS-1:0] ack_q
);

    localparam logic [NUM_MASTERS-1:0] RESET_ACK = owner_to_ack(OWN_CPU);

    logic [NUM_MASTERS-1:0] ack_d;

    // Purpose: decode the next owner into a one-hot vector.
    always_comb begin
        ack_d = owner_to_ack(owner_d);
    end

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_ack
        // Purpose: one acknowledge flop per master, CPU set on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) ack_q[m] <= RESET_ACK[m];
            else        ack_q[m] <= ack_d[m];
        end
    end

endmodule

// File: rtl/bus_owner_arb.sv
// Module: top of the two-master bus arbiter. The CPU owns the bus by default;
// the transfer engine wins when both ask, but takes the bus only at a point
// where the CPU may yield. Acknowledges are registered and exactly one is high.
module bus_owner_arb
    import bus_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_cyc_end,
    input  logic cpu_lock,
    input  logic cpu_sleep,
    input  logic xfr_req,
    output logic cpu_ack,
    output logic xfr_ack
);

    logic                   cpu_can_yield;
    owner_e                 owner_q;
    owner_e                 owner_d;
    logic [NUM_MASTERS-1:0] ack_q;

    arb_yield_gate u_gate (
        .cpu_req       (cpu_req),
        .cpu_cyc_end   (cpu_cyc_end),
        .cpu_lock      (cpu_lock),
        .cpu_sleep     (cpu_sleep),
        .cpu_can_yield (cpu_can_yield)
    );

    arb_owner_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfr_req       (xfr_req),
        .cpu_can_yield (cpu_can_yield),
        .owner_q       (owner_q),
        .owner_d       (owner_d)
    );

    arb_ack_reg u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .owner_d (owner_d),
        .ack_q   (ack_q)
    );

    // Purpose: map the acknowledge vector onto the named outputs.
    always_comb begin
        cpu_ack = ack_q[OWN_CPU];
        xfr_ack = ack_q[OWN_XFR];
    end

endmodule

// File: rtl/bus_owner_arb_chk.sv
// Module: checker for bus_owner_arb, attached by bind; observes ports only.
// Assumes inputs are stable around the rising edge.
module bus_owner_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_req,
    input logic cpu_cyc_end,
    input logic cpu_lock,
    input logic cpu_sleep,
    input logic xfr_req,
    input logic cpu_ack,
    input logic xfr_ack
);

    // Flag set from the first edge on, so nothing fires before the first edge.
    logic started;
    always_ff @(posedge clk) started <= 1'b1;

    a_r1_reset_cpu: assert property (@(posedge clk)
        !rst_n |=> (cpu_ack && !xfr_ack));

    a_r2_one_owner: assert property (@(posedge clk) disable iff (!rst_n || !started)
        $countones({cpu_ack, xfr_ack}) == 1);

    a_r3_cpu_default: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !xfr_req) |=> cpu_ack);

    a_r4_free_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && xfr_req && cpu_cyc_end && !cpu_lock) |=> xfr_ack);

    a_r5_mid_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_req && !cpu_sleep && !cpu_cyc_end) |=> cpu_ack);

    a_r6_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_req && !cpu_sleep && cpu_lock) |=> cpu_ack);

    a_r7_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && xfr_req && cpu_sleep) |=> xfr_ack);

    a_r8_cpu_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && xfr_req && !cpu_req) |=> xfr_ack);

    a_r9_xfr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfr_ack && xfr_req) |=> xfr_ack);

    a_r10_return: assert property (@(posedge clk) disable iff (!rst_n)
        (xfr_ack && !xfr_req) |=> (cpu_ack && !xfr_ack));

endmodule

bind bus_owner_arb bus_owner_arb_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_cyc_end (cpu_cyc_end),
    .cpu_lock    (cpu_lock),
    .cpu_sleep   (cpu_sleep),
    .xfr_req     (xfr_req),
    .cpu_ack     (cpu_ack),
    .xfr_ack     (xfr_ack)
);

// File: tb/tb_bus_owner_arb.sv
// Bench: walks a vector table and then runs directed tests for reset and
// locked accesses. Inputs change on the falling edge, outputs are read on
// the next falling edge.
module tb_bus_owner_arb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;

    // Row layout: {cpu_req, cpu_cyc_end, cpu_lock, cpu_sleep, xfr_req,
    //              exp_cpu_ack, exp_xfr_ack, req_tag}
    localparam logic [10:0] VEC [NVEC] = '{
        {5'b10000, 2'b10, 4'd3},   // R3  idle engine, CPU keeps bus
        {5'b11000, 2'b10, 4'd3},   // R3  strobe with no engine request
        {5'b10001, 2'b10, 4'd5},   // R5  no strobe, CPU keeps bus
        {5'b11101, 2'b10, 4'd6},   // R6  strobe with lock high
        {5'b10101, 2'b10, 4'd6},   // R6  lock high, no strobe
        {5'b11001, 2'b01, 4'd4},   // R4  free boundary hands over
        {5'b11001, 2'b01, 4'd9},   // R9  engine keeps bus
        {5'b00011, 2'b01, 4'd9},   // R9  CPU inputs ignored
        {5'b11000, 2'b10, 4'd10},  // R10 engine releases
        {5'b00001, 2'b01, 4'd8},   // R8  idle CPU yields at once
        {5'b00000, 2'b10, 4'd10},  // R10 release again
        {5'b10111, 2'b01, 4'd7},   // R7  sleep overrides lock
        {5'b10000, 2'b10, 4'd10},  // R10 release
        {5'b10000, 2'b10, 4'd3}    // R3  stays with CPU
    };

    logic clk = 1'b0;
    logic rst_n;
    logic cpu_req, cpu_cyc_end, cpu_lock, cpu_sleep, xfr_req;
    logic cpu_ack, xfr_ack;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_owner_arb dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_cyc_end (cpu_cyc_end),
        .cpu_lock    (cpu_lock),
        .cpu_sleep   (cpu_sleep),
        .xfr_req     (xfr_req),
        .cpu_ack     (cpu_ack),
        .xfr_ack     (xfr_ack)
    );

    // Compare both acknowledges against the expected pair; also checks R2.
    task automatic check_acks(input string tag, input logic [1:0] exp);
        n_checks++;
        if ({cpu_ack, xfr_ack} !== exp) begin
            n_fail++;
            $display("FAIL %s: acks actual=%b expected=%b", tag, {cpu_ack, xfr_ack}, exp);
        end
        n_checks++;
        if ($countones({cpu_ack, xfr_ack}) != 1) begin
            n_fail++;
            $display("FAIL R2: acks actual=%b expected one-hot", {cpu_ack, xfr_ack});
        end
    endtask

    // Drive inputs on a falling edge, then read after the next rising edge.
    task automatic step(input logic [4:0] in);
        {cpu_req, cpu_cyc_end, cpu_lock, cpu_sleep, xfr_req} = in;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        {cpu_req, cpu_cyc_end, cpu_lock, cpu_sleep, xfr_req} = 5'b0;
        @(negedge clk);
        @(negedge clk);
        check_acks("R1", 2'b10);              // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][10:6]);
            check_acks($sformatf("R%0d row%0d", VEC[i][3:0], i), VEC[i][5:4]);
        end

        // R6 / R4: two-word locked access; no handover between the words.
        step(5'b10101);                       // word 1 in flight, engine waiting
        check_acks("R6 word1 busy", 2'b10);
        step(5'b11101);                       // end of word 1, lock still high
        check_acks("R6 word1 end", 2'b10);
        step(5'b10001);                       // word 2 in flight, lock low
        check_acks("R5 word2 busy", 2'b10);
        step(5'b11001);                       // end of word 2: free boundary
        check_acks("R4 after longword", 2'b01);

        // R1: reset while the engine owns the bus returns it to the CPU.
        rst_n = 1'b0;
        step(5'b10001);
        check_acks("R1 reset from engine", 2'b10);
        rst_n = 1'b1;

        // R7: sleep without a strobe hands over in one clock.
        step(5'b10011);
        check_acks("R7 sleep no strobe", 2'b01);
        step(5'b10000);
        check_acks("R10 final release", 2'b10);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule